// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a 48 MHz reference clock into the 16x oversampling clock enable that a UART samples and shifts with. The divisor has two parts: an integer prescaler and a fraction counted in eighths. The baud rate is therefore 3,000,000 divided by the divisor. A single-cycle pulse, `baud_tick`, marks the end of every divisor period.

The fraction is produced by dithering. A phase accumulator adds the fraction once per period. Each period lasts the integer count of reference cycles, plus one extra cycle whenever the accumulator wraps. Over eight periods the extra cycles add up to exactly the fraction numerator.

A divisor is written on `div_int`/`div_frac` with a one-cycle `div_load` strobe. It is held pending and swapped in at the next period boundary, so a period is never cut short. The smallest divisors are handled as special cases: a divisor of exactly one gives a tick every cycle, and any fraction written with an integer of one is dropped.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low, `baud_tick` is 0 and `div_load` is ignored. After reset the generator runs with the reset divisor, 26 with fraction 0, so ticks are 26 reference cycles apart.
- R2: With fraction 0 and `div_int` n in 2..16383, consecutive ticks are exactly n reference cycles apart.
- R3: An encoded `div_int` of 0 means an integer divisor of 16384, the slowest rate.
- R4: With integer n and fraction x (`div_frac`, in eighths), the k-th period after the divisor is applied lasts n + floor(k*x/8) - floor((k-1)*x/8) cycles. Any eight consecutive periods therefore total 8n+x cycles.
- R5: `div_int`=1 with `div_frac`=0 gives a tick in every reference cycle, the 3 Mbaud setting.
- R6: `div_int`=1 with a nonzero `div_frac` is clamped to a divisor of exactly 1, so a tick occurs in every cycle.
- R7: A loaded divisor takes effect at the first period boundary after the strobe is registered. The period in progress keeps the old length, and the fraction accumulator restarts from zero when the new divisor starts.
- R8: When several loads arrive before the boundary, the last one written is the divisor that is applied.
- R9: For any divisor of 2 or more, each tick is high for exactly one cycle and is followed by at least one low cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 48 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_load | input | 1 | One-cycle strobe that captures the divisor inputs |
| div_int | input | 14 | Integer prescaler; 0 encodes 16384 |
| div_frac | input | 3 | Fraction of the divisor in eighths |
| baud_tick | output | 1 | One-cycle pulse at the end of each divisor period |

## Verification
The bench builds the block with its default parameters: a 14-bit integer field, a 3-bit fraction and a reset divisor of 26. With these values the encoded-zero divisor of 16384 can be exercised directly, since two full periods fit comfortably in the cycle budget. Every fraction pattern from one to seven eighths can also be compared period by period against a closed-form expected length. Back-to-back loads of different divisors show that the accumulator restart is visible in the very first period of each new divisor.

// File: rtl/bdg_pkg.sv
package bdg_pkg;
  localparam int BDG_INT_W    = 14;
  localparam int BDG_FRAC_W   = 3;
  localparam int BDG_RST_INT  = 26;
  localparam int BDG_RST_FRAC = 0;

  typedef enum logic {
    SRC_ACTIVE  = 1'b0,
    SRC_PENDING = 1'b1
  } div_src_e;
endpackage

// File: rtl/bdg_div_hold.sv
module bdg_div_hold
  import bdg_pkg::*;
#(
  parameter int INT_W    = BDG_INT_W,
  parameter int FRAC_W   = BDG_FRAC_W,
  parameter int RST_INT  = BDG_RST_INT,
  parameter int RST_FRAC = BDG_RST_FRAC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              boundary_i,
  output logic [INT_W:0]    dec_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              restart_o
);

  // integer field 0 stands for 2**INT_W
  function automatic logic [INT_W:0] decode_int(input logic [INT_W-1:0] v);
    if (v == '0) return (INT_W+1)'(1) << INT_W;
    return {1'b0, v};
  endfunction

  // a divisor of one cannot carry a fraction
  function automatic logic [FRAC_W-1:0] clamp_frac(input logic [INT_W:0] dec,
                                                   input logic [FRAC_W-1:0] x);
    if (dec == (INT_W+1)'(1)) return '0;
    return x;
  endfunction

  logic [INT_W-1:0]  pend_int, act_int, sel_int;
  logic [FRAC_W-1:0] pend_frac, act_frac, sel_frac;
  logic              pend_vld;
  div_src_e          src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_int  <= '0;
      pend_frac <= '0;
      pend_vld  <= 1'b0;
    end else if (load_i) begin
      pend_int  <= int_i;
      pend_frac <= frac_i;
      pend_vld  <= 1'b1;
    end else if (boundary_i) begin
      pend_vld  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_int  <= INT_W'(RST_INT);
      act_frac <= FRAC_W'(RST_FRAC);
    end else if (boundary_i && pend_vld) begin
      act_int  <= pend_int;
      act_frac <= pend_frac;
    end
  end

  always_comb begin
    src      = pend_vld ? SRC_PENDING : SRC_ACTIVE;
    sel_int  = (src == SRC_PENDING) ? pend_int  : act_int;
    sel_frac = (src == SRC_PENDING) ? pend_frac : act_frac;
  end

  assign dec_o     = decode_int(sel_int);
  assign frac_o    = clamp_frac(dec_o, sel_frac);
  assign restart_o = pend_vld;

  // R7: the running divisor only changes at a boundary with a pending write
  assert_active_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(boundary_i && pend_vld) |=> ($stable(act_int) && $stable(act_frac)));

  // R8: a load always leaves a pending divisor behind
  assert_pending_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> restart_o);

  // R3: the decoded integer is never zero
  assert_decode_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_o != '0);

endmodule

// File: rtl/bdg_frac_step.sv
module bdg_frac_step
  import bdg_pkg::*;
#(
  parameter int INT_W  = BDG_INT_W,
  parameter int FRAC_W = BDG_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              restart_i,
  input  logic [INT_W:0]    dec_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [INT_W:0]    len_o,
  output logic              carry_o
);

  logic [FRAC_W-1:0] phase;
  logic [FRAC_W-1:0] base;
  logic [FRAC_W:0]   sum;

  function automatic logic [FRAC_W:0] add_phase(input logic [FRAC_W-1:0] p,
                                                input logic [FRAC_W-1:0] x);
    return {1'b0, p} + {1'b0, x};
  endfunction

  assign base    = restart_i ? '0 : phase;
  assign sum     = add_phase(base, frac_i);
  assign carry_o = sum[FRAC_W];
  assign len_o   = dec_i + (INT_W+1)'(carry_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase <= '0;
    else if (boundary_i) phase <= sum[FRAC_W-1:0];
  end

  // R7: the first period of a freshly applied divisor never stretches
  assert_first_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && restart_i) |-> !carry_o);

  // R6: a divisor of one always yields a one-cycle period
  assert_clamp_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && dec_i == (INT_W+1)'(1)) |-> len_o == (INT_W+1)'(1));

  // R4: a period is the integer part or one more
  assert_len_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_i |-> (len_o >= dec_i && (len_o - dec_i) <= (INT_W+1)'(1)));

endmodule

// File: rtl/bdg_tick_ctr.sv
module bdg_tick_ctr
  import bdg_pkg::*;
#(
  parameter int LEN_W = BDG_INT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] len_i,
  output logic             boundary_o,
  output logic             tick_o
);

  logic [LEN_W-1:0] remain;

  assign boundary_o = (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      tick_o <= 1'b0;
    end else if (boundary_o) begin
      remain <= len_i - LEN_W'(1);
      tick_o <= 1'b1;
    end else begin
      remain <= remain - LEN_W'(1);
      tick_o <= 1'b0;
    end
  end

  // R9: a tick that opens a period longer than one cycle lasts one cycle
  assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_o && len_i != LEN_W'(1)) |=> (tick_o ##1 !tick_o));

  // R5: the period length handed in is never zero
  assert_len_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_o |-> len_i != '0);

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import bdg_pkg::*;
#(
  parameter int INT_W    = BDG_INT_W,
  parameter int FRAC_W   = BDG_FRAC_W,
  parameter int RST_INT  = BDG_RST_INT,
  parameter int RST_FRAC = BDG_RST_FRAC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_load,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              baud_tick
);

  localparam int LEN_W = INT_W + 1;

  logic              boundary;
  logic              restart;
  logic              carry;
  logic [LEN_W-1:0]  dec_n;
  logic [LEN_W-1:0]  next_len;
  logic [FRAC_W-1:0] eff_frac;

  bdg_div_hold #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .RST_INT(RST_INT), .RST_FRAC(RST_FRAC)
  ) u_hold (
    .clk(clk), .rst_n(rst_n), .load_i(div_load), .int_i(div_int),
    .frac_i(div_frac), .boundary_i(boundary), .dec_o(dec_n),
    .frac_o(eff_frac), .restart_o(restart)
  );

  bdg_frac_step #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_step (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .restart_i(restart),
    .dec_i(dec_n), .frac_i(eff_frac), .len_o(next_len), .carry_o(carry)
  );

  bdg_tick_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .len_i(next_len),
    .boundary_o(boundary), .tick_o(baud_tick)
  );

  // R4: the extra cycle only appears when a fraction is in use
  assert_carry_needs_frac_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && eff_frac == '0) |-> !carry);

endmodule

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // columns: integer field, fraction in eighths, periods to measure
  localparam int VEC [0:NVEC-1][0:2] = '{
    '{2, 0, 8}, '{3, 1, 16}, '{2, 4, 16}, '{5, 7, 16}, '{1, 0, 8},
    '{1, 5, 8}, '{7, 3, 16}, '{4, 0, 8}, '{11, 6, 16}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_load = 1'b0;
  logic [13:0] div_int = '0;
  logic [2:0]  div_frac = '0;
  logic        baud_tick;

  int checks = 0;
  int fails = 0;

  frac_baud_gen uut (
    .clk(clk), .rst_n(rst_n), .div_load(div_load),
    .div_int(div_int), .div_frac(div_frac), .baud_tick(baud_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog R1..R9 run actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic int exp_len(input int n, input int x, input int k);
    int dn = (n == 0) ? 16384 : n;
    int xe = (dn == 1) ? 0 : x;
    return dn + (k * xe) / 8 - ((k - 1) * xe) / 8;
  endfunction

  function automatic string tag_for(input int n, input int x);
    if (n == 0) return "R3";
    if (n == 1 && x == 0) return "R5";
    if (n == 1) return "R6";
    if (x == 0) return "R2";
    return "R4";
  endfunction

  task automatic wait_tick(output time t);
    do @(negedge clk); while (baud_tick !== 1'b1);
    t = $time;
  endtask

  task automatic load_div(input int n, input int x);
    @(negedge clk);
    div_int = 14'(n); div_frac = 3'(x); div_load = 1'b1;
    @(negedge clk);
    div_load = 1'b0;
  endtask

  // load, find the boundary tick, then compare each period
  task automatic run_vec(input int n, input int x, input int periods, input string tag);
    time t0, t1;
    int sum8;
    load_div(n, x);
    wait_tick(t0);
    sum8 = 0;
    for (int k = 1; k <= periods; k++) begin
      wait_tick(t1);
      check(tag, int'((t1 - t0) / CLK_PERIOD), exp_len(n, x, k));
      if (k <= 8) sum8 += int'((t1 - t0) / CLK_PERIOD);
      t0 = t1;
    end
    if (periods >= 8 && n > 1)
      check("R4 eight-period total", sum8, 8 * n + x);
  endtask

  initial begin
    time t0, t1;
    // R1: reset holds the tick low and ignores loads
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      div_int = 14'd3; div_load = (i == 1);
      check("R1 tick in reset", int'(baud_tick), 0);
    end
    div_load = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    wait_tick(t0);
    for (int k = 0; k < 3; k++) begin
      wait_tick(t1);
      check("R1 reset divisor", int'((t1 - t0) / CLK_PERIOD), 26);
      t0 = t1;
    end

    for (int i = 0; i < NVEC; i++)
      run_vec(VEC[i][0], VEC[i][1], VEC[i][2], tag_for(VEC[i][0], VEC[i][1]));

    // R3: encoded zero is the largest divisor
    run_vec(0, 0, 2, "R3");

    // R7 and R8: old period completes, last of two loads wins
    run_vec(20, 0, 2, "R2");
    wait_tick(t0);
    div_int = 14'd3; div_frac = 3'd0; div_load = 1'b1;
    @(negedge clk);
    div_int = 14'd6;
    @(negedge clk);
    div_load = 1'b0;
    wait_tick(t1);
    check("R7 old period kept", int'((t1 - t0) / CLK_PERIOD), 20);
    t0 = t1;
    for (int k = 0; k < 4; k++) begin
      wait_tick(t1);
      check("R8 last load applied", int'((t1 - t0) / CLK_PERIOD), 6);
      t0 = t1;
    end

    // R9: single-cycle pulse with divisor 3
    run_vec(3, 0, 2, "R2");
    wait_tick(t0);
    @(negedge clk);
    check("R9 tick low after pulse", int'(baud_tick), 0);
    @(negedge clk);
    check("R9 tick low mid period", int'(baud_tick), 0);
    @(negedge clk);
    check("R9 next tick", int'(baud_tick), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule